// File: doc/BRIEF.md
# Serial Frame Receiver with Error Flags

This block turns an asynchronous serial line into parallel words. It watches one of several input pins for the falling edge that opens a frame. It restarts its bit timer from that edge, so every later sample lands near the centre of its bit. It then gathers 5 to 8 data bits, least significant first, and an optional parity bit. The assembled word goes into a one-entry holding buffer half a bit after the last data or parity sample. One bit period after that sample, the stop bit is sampled, an interrupt pulse is raised, and any parity, framing or overrun problem is recorded in a sticky flag.

Software enables the unit, chooses receive direction, the input pin, the word length, the parity mode and the number of system clocks per bit. Frames are taken one after another until the enable is dropped. The enable is best cleared between the stop-bit sample and the next start edge. Clearing it inside a frame throws that frame away.

The buffered word is offered on a valid/ready read port. `rd_valid` stays high and `rd_data` stays unchanged until a cycle with `rd_ready` high takes the word. The only exception is a newer frame arriving first: it replaces the word and raises the overrun flag. The serial side cannot be stalled, so back-pressure never reaches the line.

Top module: `uart_rx_unit`

## Requirements
- R1: After reset `rd_valid`, `irq` and all three error flags are 0.
- R2: Frames are received only while `en` is 1 and `dir_tx` is 0. In any other setting, line activity loads no word and raises no `irq`.
- R3: Only the pin chosen by `pin_sel` is watched (value 0 selects `rx_in[0]`, value 1 selects `rx_in[1]`). Traffic on the other pin has no effect.
- R4: A start edge whose line is high again at the mid-bit check is a false start. The unit returns to idle without loading a word, and the next real frame is received correctly.
- R5: Data bits arrive least significant first. `len_sel` value n gives 5+n data bits (0→5 … 3→8). The word appears right-justified in `rd_data`, with unused upper bits 0.
- R6: `par_mode` 0 and 3 mean no parity bit, 1 means even parity and 2 means odd parity. A parity bit that does not match sets `err_par`.
- R7: A stop bit sampled low sets `err_frm`.
- R8: When a word is loaded while the previous one is still untaken, `err_ovr` is set and the buffer holds the newer word.
- R9: Each received frame gives exactly one single-cycle `irq` pulse. The word is already in the buffer when the pulse appears.
- R10: Error flags stay set until a 1 is written to their clear bit in `clr_flags` (bit 0 parity, bit 1 overrun, bit 2 framing). A 0 leaves the flag untouched.
- R11: `rd_valid` stays high until a cycle with `rd_ready` high. After that handshake `rd_valid` is 0 if no new word arrived.
- R12: Frames that follow each other with no idle time between stop bit and next start bit are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable |
| dir_tx | input | 1 | Direction select; 0 = receive |
| pin_sel | input | 1 | Selects the watched serial pin |
| len_sel | input | 2 | Data length code, 5+n bits |
| par_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| baud_div | input | 16 | System clocks per bit, 8 or more |
| rx_in | input | 2 | Serial input pins |
| rd_valid | output | 1 | Buffer holds an untaken word |
| rd_ready | input | 1 | Reader takes the word |
| rd_data | output | 8 | Received word, right-justified |
| irq | output | 1 | One-cycle pulse per frame |
| err_par | output | 1 | Sticky parity error |
| err_ovr | output | 1 | Sticky overrun error |
| err_frm | output | 1 | Sticky framing error |
| clr_flags | input | 3 | Write-1-to-clear for the error flags |

## Verification
Some rules are checked on every cycle: `irq` never lasts past one cycle, no pulse follows a cycle in which reception was off, each error flag only drops after its clear bit was written, and an offered word is not withdrawn without a handshake. Other behaviour only shows up in the bench's frame scenarios. That covers correct bit order and justification for every length, parity judgement in each mode, pin selection, false-start recovery, overrun replacement and back-to-back frames. These can only be judged against words the bench built itself.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int LEN_W = 2;

  typedef struct packed {
    logic frm;
    logic ovr;
    logic par;
  } rx_flags_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int NPIN  = 2,
  parameter int SEL_W = $clog2(NPIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  rx_in,
  input  logic [SEL_W-1:0] sel,
  output logic             rx_s,
  output logic             rx_fall
);

  logic [NPIN-1:0] synced;
  logic            prev;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= 2'b11;
      else        ff <= {ff[0], rx_in[p]};
    end
    assign synced[p] = ff[1];
  end

  assign rx_s = synced[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= rx_s;
  end

  assign rx_fall = prev & ~rx_s;

endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt;
  logic             armed;
  logic [DIV_W-1:0] half_m1;

  assign half_m1 = (div >> 1) - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= half_m1;
      armed <= 1'b0;
    end else if (run) begin
      if (cnt == '0) begin
        cnt   <= div - 1'b1;
        armed <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign rise = run && !restart && (cnt == '0);
  assign fall = run && !restart && armed && (cnt == half_m1);

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rx_s,
  input  logic              rx_fall,
  input  logic              rise,
  input  logic              fall,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic [1:0]        par_mode,
  output logic              restart,
  output logic              run,
  output logic              ld_stb,
  output logic [DATA_W-1:0] ld_word,
  output logic              chk_stb,
  output logic              par_bad,
  output logic              frm_bad,
  output logic              irq
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] DW   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] MINL = CNT_W'(MIN_LEN);

  rx_state_e         state;
  logic [LEN_W-1:0]  lenq;
  par_mode_e         pm;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              ld_pend;

  logic [CNT_W-1:0]  nbits;
  logic              par_on;

  assign nbits  = MINL + CNT_W'(lenq);
  assign par_on = (pm == PAR_EVEN) || (pm == PAR_ODD);

  assign restart = active && (state == ST_IDLE) && rx_fall;
  assign run     = active && (state != ST_IDLE);
  assign ld_stb  = active && (state == ST_STOP) && ld_pend && fall;
  assign ld_word = shreg >> (DW - nbits);
  assign chk_stb = active && (state == ST_STOP) && rise;
  assign frm_bad = ~rx_s;
  assign par_bad = par_on && (par_acc ^ (pm == PAR_ODD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lenq    <= '0;
      pm      <= PAR_NONE;
      bitcnt  <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      ld_pend <= 1'b0;
      irq     <= 1'b0;
    end else if (!active) begin
      state   <= ST_IDLE;
      ld_pend <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= chk_stb;
      case (state)
        ST_IDLE: begin
          if (rx_fall) begin
            state   <= ST_START;
            lenq    <= len_sel;
            pm      <= par_mode_e'(par_mode);
            bitcnt  <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
          end
        end
        ST_START: begin
          if (rise) state <= rx_s ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (rise) begin
            shreg   <= {rx_s, shreg[DATA_W-1:1]};
            par_acc <= par_acc ^ rx_s;
            bitcnt  <= bitcnt + 1'b1;
            if (bitcnt == nbits - 1'b1) begin
              if (par_on) begin
                state <= ST_PAR;
              end else begin
                state   <= ST_STOP;
                ld_pend <= 1'b1;
              end
            end
          end
        end
        ST_PAR: begin
          if (rise) begin
            par_acc <= par_acc ^ rx_s;
            state   <= ST_STOP;
            ld_pend <= 1'b1;
          end
        end
        ST_STOP: begin
          if (fall && ld_pend) ld_pend <= 1'b0;
          if (rise)            state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic [DATA_W-1:0] ld_word,
  input  logic              chk_stb,
  input  logic              par_bad,
  input  logic              frm_bad,
  input  logic              rd_ready,
  input  logic [2:0]        clr_flags,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output rx_flags_t         flags
);

  logic      full;
  logic      ovr_pend;
  rx_flags_t set_v;
  rx_flags_t clr_v;

  assign rd_valid = full;
  assign clr_v    = rx_flags_t'(clr_flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      rd_data <= '0;
    end else if (ld_stb) begin
      full    <= 1'b1;
      rd_data <= ld_word;
    end else if (full && rd_ready) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_pend <= 1'b0;
    else if (chk_stb) ovr_pend <= 1'b0;
    else if (ld_stb)  ovr_pend <= full && !rd_ready;
  end

  always_comb begin
    set_v.par = chk_stb && par_bad;
    set_v.frm = chk_stb && frm_bad;
    set_v.ovr = chk_stb && ovr_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;
  end

endmodule

// File: rtl/uart_rx_unit.sv
module uart_rx_unit
  import uart_rx_pkg::*;
#(
  parameter int NPIN    = 2,
  parameter int DIV_W   = 16,
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  localparam int SEL_W  = $clog2(NPIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dir_tx,
  input  logic [SEL_W-1:0]  pin_sel,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic [1:0]        par_mode,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [NPIN-1:0]   rx_in,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              err_par,
  output logic              err_ovr,
  output logic              err_frm,
  input  logic [2:0]        clr_flags
);

  logic              active;
  logic              rx_s, rx_fall;
  logic              restart, run, rise, fall;
  logic              ld_stb, chk_stb, par_bad, frm_bad;
  logic [DATA_W-1:0] ld_word;
  rx_flags_t         flags;

  assign active = en & ~dir_tx;

  uart_rx_sync #(.NPIN(NPIN), .SEL_W(SEL_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .sel(pin_sel),
    .rx_s(rx_s), .rx_fall(rx_fall)
  );

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .div(baud_div), .rise(rise), .fall(fall)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active), .rx_s(rx_s),
    .rx_fall(rx_fall), .rise(rise), .fall(fall), .len_sel(len_sel),
    .par_mode(par_mode), .restart(restart), .run(run), .ld_stb(ld_stb),
    .ld_word(ld_word), .chk_stb(chk_stb), .par_bad(par_bad),
    .frm_bad(frm_bad), .irq(irq)
  );

  uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_word(ld_word),
    .chk_stb(chk_stb), .par_bad(par_bad), .frm_bad(frm_bad),
    .rd_ready(rd_ready), .clr_flags(clr_flags), .rd_valid(rd_valid),
    .rd_data(rd_data), .flags(flags)
  );

  assign err_par = flags.par;
  assign err_ovr = flags.ovr;
  assign err_frm = flags.frm;

endmodule

// File: rtl/uart_rx_unit_chk.sv
module uart_rx_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       dir_tx,
  input logic       irq,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       err_par,
  input logic       err_ovr,
  input logic       err_frm,
  input logic [2:0] clr_flags
);

  a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r2_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && !dir_tx) |=> !irq);

  a_r11_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);

  a_r10_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_par && !clr_flags[0]) |=> err_par);

  a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovr && !clr_flags[1]) |=> err_ovr);

  a_r10_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frm && !clr_flags[2]) |=> err_frm);

endmodule

bind uart_rx_unit uart_rx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dir_tx(dir_tx), .irq(irq),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .err_par(err_par),
  .err_ovr(err_ovr), .err_frm(err_frm), .clr_flags(clr_flags)
);

// File: tb/sim_uart_rx_unit.sv
module sim_uart_rx_unit;

  localparam int CLK_T = 10;
  localparam int DIV   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, dir_tx = 1'b0;
  logic [0:0] pin_sel = 1'b0;
  logic [1:0] len_sel = 2'd3, par_mode = 2'd0;
  logic [15:0] baud_div = 16'(DIV);
  logic [1:0] rx = 2'b11;
  logic       rd_valid, rd_ready, irq, err_par, err_ovr, err_frm;
  logic       man_rd = 1'b0, auto_rd = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] clr = 3'd0;

  int n_cmp = 0, n_bad = 0, irq_seen = 0, n_got = 0;
  int got_w [0:15];

  assign rd_ready = man_rd | auto_rd;

  always #(CLK_T/2) clk = ~clk;

  uart_rx_unit u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .dir_tx(dir_tx), .pin_sel(pin_sel),
    .len_sel(len_sel), .par_mode(par_mode), .baud_div(baud_div), .rx_in(rx),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .irq(irq),
    .err_par(err_par), .err_ovr(err_ovr), .err_frm(err_frm), .clr_flags(clr)
  );

  always @(negedge clk) begin
    if (rst_n && irq) irq_seen++;
    if (rst_n && rd_valid && rd_ready && auto_rd) begin
      got_w[n_got % 16] = int'(rd_data);
      n_got++;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bit_out(int pin, logic v);
    rx[pin] = v;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic send(int pin, int data, int nb, int pm, bit flip, bit stopv, int idle);
    int mask = (1 << nb) - 1;
    logic p;
    bit_out(pin, 1'b0);
    for (int i = 0; i < nb; i++) bit_out(pin, data[i]);
    if (pm == 1 || pm == 2) begin
      p = ^(data & mask);
      if (pm == 2) p = ~p;
      bit_out(pin, p ^ flip);
    end
    bit_out(pin, stopv);
    rx[pin] = 1'b1;
    repeat (idle * DIV) @(negedge clk);
  endtask

  task automatic take();
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
  endtask

  task automatic clear(logic [2:0] c);
    clr = c;
    @(negedge clk);
    clr = 3'd0;
  endtask

  task automatic expect_word(string req, int base, int w, int pe, int oe, int fe);
    chk(req, "irq pulses", irq_seen - base, 1);
    chk(req, "valid", int'(rd_valid), 1);
    chk(req, "data", int'(rd_data), w);
    chk(req, "err_par", int'(err_par), pe);
    chk(req, "err_ovr", int'(err_ovr), oe);
    chk(req, "err_frm", int'(err_frm), fe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base, w, nb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid", int'(rd_valid), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "flags", int'({err_par, err_ovr, err_frm}), 0);

    // R2 disabled, then transmit direction
    base = irq_seen;
    send(0, 8'h5A, 8, 0, 0, 1, 2);
    chk("R2", "irq when disabled", irq_seen - base, 0);
    chk("R2", "valid when disabled", int'(rd_valid), 0);
    en = 1'b1; dir_tx = 1'b1;
    send(0, 8'hA5, 8, 0, 0, 1, 2);
    chk("R2", "irq in tx mode", irq_seen - base, 0);
    chk("R2", "valid in tx mode", int'(rd_valid), 0);
    dir_tx = 1'b0;
    repeat (DIV) @(negedge clk);

    // R3 unselected pin ignored
    send(1, 8'h3C, 8, 0, 0, 1, 2);
    chk("R3", "irq from other pin", irq_seen - base, 0);
    chk("R3", "valid from other pin", int'(rd_valid), 0);

    // R4 false start then a real frame
    rx[0] = 1'b0;
    repeat (2) @(negedge clk);
    rx[0] = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    chk("R4", "irq after glitch", irq_seen - base, 0);
    chk("R4", "valid after glitch", int'(rd_valid), 0);
    send(0, 8'hC3, 8, 0, 0, 1, 1);
    expect_word("R4", base, 8'hC3, 0, 0, 0);
    take();

    // R5 R6 R3 sweep over pin, length, parity mode and data
    for (int pin = 0; pin < 2; pin++)
      for (int ln = 0; ln < 4; ln++)
        for (int pm = 0; pm < 4; pm++)
          for (int k = 0; k < 12; k++) begin
            nb = 5 + ln;
            w = (k * 37 + pin * 11 + ln * 5 + pm * 3) & ((1 << nb) - 1);
            pin_sel = 1'(pin); len_sel = 2'(ln); par_mode = 2'(pm);
            base = irq_seen;
            send(pin, w, nb, pm, 0, 1, 1);
            expect_word("R5", base, w, 0, 0, 0);
            take();
            chk("R11", "valid after take", int'(rd_valid), 0);
          end

    // R5 all byte values, 8 bits, no parity
    pin_sel = 1'b0; len_sel = 2'd3; par_mode = 2'd0;
    for (int d = 0; d < 256; d++) begin
      send(0, d, 8, 0, 0, 1, 1);
      chk("R5", "byte sweep data", int'(rd_data), d);
      take();
    end

    // R6 parity errors, R10 sticky and clear
    par_mode = 2'd1;
    base = irq_seen;
    send(0, 8'h17, 8, 1, 1, 1, 1);
    expect_word("R6", base, 8'h17, 1, 0, 0);
    take();
    chk("R10", "par stays after take", int'(err_par), 1);
    clear(3'b001);
    chk("R10", "par cleared", int'(err_par), 0);
    par_mode = 2'd2; len_sel = 2'd0;
    base = irq_seen;
    send(0, 5'h0B, 5, 2, 1, 1, 1);
    expect_word("R6", base, 5'h0B, 1, 0, 0);
    take();
    clear(3'b111);

    // R7 framing error; R10 partial clear
    par_mode = 2'd1; len_sel = 2'd3;
    base = irq_seen;
    send(0, 8'h81, 8, 1, 1, 0, 2);
    expect_word("R7", base, 8'h81, 1, 0, 1);
    take();
    clear(3'b001);
    chk("R10", "par after own clear", int'(err_par), 0);
    chk("R10", "frm untouched", int'(err_frm), 1);
    clear(3'b100);
    chk("R10", "frm cleared", int'(err_frm), 0);

    // R8 overrun, R11 back-pressure hold
    par_mode = 2'd0;
    base = irq_seen;
    send(0, 8'h11, 8, 0, 0, 1, 1);
    repeat (4 * DIV) @(negedge clk);
    chk("R11", "held valid", int'(rd_valid), 1);
    chk("R11", "held data", int'(rd_data), 8'h11);
    send(0, 8'h22, 8, 0, 0, 1, 1);
    chk("R8", "irq pulses", irq_seen - base, 2);
    chk("R8", "newest data", int'(rd_data), 8'h22);
    chk("R8", "err_ovr", int'(err_ovr), 1);
    take();
    clear(3'b010);
    chk("R10", "ovr cleared", int'(err_ovr), 0);

    // R12 back-to-back frames with a live reader
    auto_rd = 1'b1;
    base = n_got;
    send(0, 8'h9E, 8, 0, 0, 1, 0);
    send(0, 8'h01, 8, 0, 0, 1, 0);
    send(0, 8'hF0, 8, 0, 0, 1, 2);
    auto_rd = 1'b0;
    chk("R12", "words taken", n_got - base, 3);
    chk("R12", "word 0", got_w[base % 16], 8'h9E);
    chk("R12", "word 1", got_w[(base + 1) % 16], 8'h01);
    chk("R12", "word 2", got_w[(base + 2) % 16], 8'hF0);
    chk("R12", "no overrun", int'(err_ovr), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule